// File: doc/BRIEF.md
# Random Word Fetch Register

This block keeps a single random word obtained from an entropy source and makes it available to software through two read-only registers. One register holds the word and the other reports whether the word is valid and whether the source marked it as FIPS quality. The block fetches the word over a simple request/acknowledge handshake. It holds the request high until the source acknowledges, and it captures the word and its quality flag in that acknowledge cycle.

Reading the word register while the word is valid has a side effect. The read returns the word in the same cycle, marks the word as used, and starts a fresh fetch on the next cycle. While a fetch is outstanding, the word register reads as zero. A read made during that time changes nothing. Out of reset the word is invalid and a fetch is already running, so software finds fresh entropy once the source first answers.

Top module: `rnd_word_reg`

## Requirements
- R1: After reset, `entReq` is 1, the status register (address 1) reads 0 and the word register (address 0) reads 0.
- R2: Once asserted, `entReq` stays 1 in every cycle until a cycle in which `entAck` is 1. In the cycle after that acknowledge, `entReq` is 0.
- R3: An acknowledge while `entReq` is 1 captures `entData` and `entFips`. From the next cycle, the status register reads bit 0 (valid) = 1 and bit 1 (quality) = the captured `entFips`, with bits 31:2 = 0.
- R4: A read (`rdEn` = 1, `rdAddr` = 0) while the word is valid returns the stored word on `rdData` in that same cycle. In the next cycle, valid is 0 and `entReq` is 1.
- R5: While valid is 0, reading address 0 returns 0, and status bit 1 reads 0 whatever quality flag was last captured.
- R6: A read of address 0 while valid is 0 has no effect: `entReq` stays 1 without a gap, and the next acknowledge is captured as usual.
- R7: Reading the status register (address 1) has no side effect: valid and the word stay as they were.
- R8: An `entAck` that arrives while `entReq` is 0 is ignored. The stored word and quality flag do not change.
- R9: Reading any address other than 0 or 1 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| entReq | output | 1 | Entropy request, held until acknowledged |
| entAck | input | 1 | Entropy acknowledge; word valid in this cycle |
| entData | input | 32 | Random word from the entropy source |
| entFips | input | 1 | Quality flag delivered with the word |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 2 | Register read address (0 word, 1 status) |
| rdData | output | 32 | Read data, combinational on `rdAddr` |

## Verification
The assertions watch three things on every cycle. They check that the request is held until an acknowledge and then drops. They check that a consuming read forces a re-request in the next cycle, and that a read while invalid leaves the state alone. They also check that the word register reads zero while invalid, and that the stored word changes only in a capture cycle. Only the bench scenarios can show that software sees the correct word and quality values for different acknowledge delays. The same holds for the absence of side effects from status reads and stray acknowledges, which is seen through later reads, and for the zero returned by unmapped addresses.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  typedef struct packed {
    logic capture;
    logic consume;
  } rwfStrobe_t;

  typedef enum logic {
    StFetch = 1'b0,
    StHold  = 1'b1
  } rwfState_e;
endpackage

// File: rtl/rwf_ctrl.sv
module rwf_ctrl
  import rwf_pkg::*;
#(
  parameter int RegAddrW = 2,
  parameter logic [RegAddrW-1:0] DataAddr = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                entAck,
  input  logic                rdEn,
  input  logic [RegAddrW-1:0] rdAddr,
  output logic                entReq,
  output logic                wordValid,
  output rwfStrobe_t          strobes
);
  rwfState_e stateQ, stateD;

  // A read of the word register counts as a consume only while the word is held.
  always_comb begin
    strobes.capture = (stateQ == StFetch) && entAck;
    strobes.consume = (stateQ == StHold) && rdEn && (rdAddr == DataAddr);
    stateD = stateQ;
    if (strobes.capture) stateD = StHold;
    if (strobes.consume) stateD = StFetch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= StFetch;
    else       stateQ <= stateD;
  end

  assign entReq    = (stateQ == StFetch);
  assign wordValid = (stateQ == StHold);

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    entReq && !entAck |=> entReq);
  assert_req_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    entReq && entAck |=> !entReq && wordValid);
  assert_consume_R4: assert property (@(posedge clk) disable iff (!rstN)
    wordValid && rdEn && rdAddr == DataAddr |=> entReq && !wordValid);
  assert_no_side_R6: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid && !entAck |=> !wordValid && entReq);
endmodule

// File: rtl/rwf_datapath.sv
module rwf_datapath
  import rwf_pkg::*;
#(
  parameter int DataWidth = 32,
  parameter int RegAddrW  = 2,
  parameter logic [RegAddrW-1:0] DataAddr   = '0,
  parameter logic [RegAddrW-1:0] StatusAddr = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rwfStrobe_t           strobes,
  input  logic                 wordValid,
  input  logic [DataWidth-1:0] entData,
  input  logic                 entFips,
  input  logic [RegAddrW-1:0]  rdAddr,
  output logic [DataWidth-1:0] rdData
);
  localparam int StatusPad = DataWidth - 2;

  logic [DataWidth-1:0] wordQ;
  logic                 fipsQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= '0;
      fipsQ <= 1'b0;
    end else if (strobes.capture) begin
      wordQ <= entData;
      fipsQ <= entFips;
    end
  end

  // The stored word and flag are masked by valid, so a consumed word never leaks.
  always_comb begin
    rdData = '0;
    if (rdAddr == DataAddr)        rdData = wordValid ? wordQ : '0;
    else if (rdAddr == StatusAddr) rdData = {{StatusPad{1'b0}}, fipsQ & wordValid, wordValid};
  end

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> wordQ == $past(entData) && fipsQ == $past(entFips));
  assert_ignore_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(wordQ) && $stable(fipsQ));
  assert_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid && rdAddr == DataAddr |-> rdData == '0);
endmodule

// File: rtl/rnd_word_reg.sv
module rnd_word_reg
  import rwf_pkg::*;
#(
  parameter int DataWidth = 32,
  parameter int RegAddrW  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  output logic                 entReq,
  input  logic                 entAck,
  input  logic [DataWidth-1:0] entData,
  input  logic                 entFips,
  input  logic                 rdEn,
  input  logic [RegAddrW-1:0]  rdAddr,
  output logic [DataWidth-1:0] rdData
);
  localparam logic [RegAddrW-1:0] DataAddr   = '0;
  localparam logic [RegAddrW-1:0] StatusAddr = 1;

  rwfStrobe_t strobes;
  logic       wordValid;

  rwf_ctrl #(.RegAddrW(RegAddrW), .DataAddr(DataAddr)) u_ctrl (
    .clk(clk), .rstN(rstN), .entAck(entAck), .rdEn(rdEn), .rdAddr(rdAddr),
    .entReq(entReq), .wordValid(wordValid), .strobes(strobes)
  );

  rwf_datapath #(.DataWidth(DataWidth), .RegAddrW(RegAddrW),
                 .DataAddr(DataAddr), .StatusAddr(StatusAddr)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wordValid(wordValid),
    .entData(entData), .entFips(entFips), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/rnd_word_reg_tb.sv
module rnd_word_reg_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic entReq, entAck = 1'b0, entFips = 1'b0, rdEn = 1'b0;
  logic [31:0] entData = '0;
  logic [1:0]  rdAddr = 2'd0;
  logic [31:0] rdData;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rnd_word_reg u_dut (.clk(clk), .rstN(rstN), .entReq(entReq), .entAck(entAck),
    .entData(entData), .entFips(entFips), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData));

  // word, quality flag, cycles before acknowledge
  localparam logic [40:0] Vecs [6] = '{
    {32'hDEADBEEF, 1'b1, 8'd0}, {32'h12345678, 1'b0, 8'd3},
    {32'hFFFFFFFF, 1'b1, 8'd1}, {32'h00000001, 1'b0, 8'd7},
    {32'hA5A55A5A, 1'b1, 8'd2}, {32'h80000000, 1'b1, 8'd5}};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readAt(logic [1:0] a, bit en, output logic [31:0] v);
    rdAddr = a; rdEn = en; #1; v = rdData;
  endtask

  task automatic ackWord(logic [31:0] w, logic f);
    entAck = 1'b1; entData = w; entFips = f;
    @(negedge clk);
    entAck = 1'b0; entData = '0; entFips = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    readAt(2'd1, 1'b0, v); check("R1 status", v, 32'h0);
    readAt(2'd0, 1'b0, v); check("R1 word", v, 32'h0);
    check("R1 req", {31'b0, entReq}, 32'h1);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      for (int d = 0; d < int'(Vecs[i][7:0]); d++) begin
        check("R2 req held", {31'b0, entReq}, 32'h1);
        @(negedge clk);
      end
      ackWord(Vecs[i][40:9], Vecs[i][8]);
      check("R2 req drop", {31'b0, entReq}, 32'h0);
      readAt(2'd1, 1'b1, v); check("R3 status", v, {30'b0, Vecs[i][8], 1'b1});
      readAt(2'd0, 1'b1, v); check("R4 word", v, Vecs[i][40:9]);
      @(negedge clk);
      rdEn = 1'b0;
      check("R4 re-request", {31'b0, entReq}, 32'h1);
      readAt(2'd0, 1'b0, v); check("R5 word zero", v, 32'h0);
      readAt(2'd1, 1'b0, v); check("R5 status zero", v, 32'h0);
    end

    // R6: reads while invalid leave the fetch running
    for (int k = 0; k < 4; k++) begin
      readAt(2'd0, 1'b1, v);
      @(negedge clk);
      check("R6 req steady", {31'b0, entReq}, 32'h1);
    end
    rdEn = 1'b0;
    ackWord(32'hCAFEF00D, 1'b1);
    readAt(2'd1, 1'b0, v); check("R6 capture after idle reads", v, 32'h3);

    // R7: status reads do not consume
    for (int k = 0; k < 3; k++) begin
      readAt(2'd1, 1'b1, v);
      @(negedge clk);
    end
    rdEn = 1'b0;
    readAt(2'd1, 1'b0, v); check("R7 valid kept", v, 32'h3);

    // R8: stray acknowledge while not requesting
    ackWord(32'h11112222, 1'b0);
    readAt(2'd1, 1'b0, v); check("R8 flag kept", v, 32'h3);
    readAt(2'd0, 1'b0, v); check("R8 word kept", v, 32'hCAFEF00D);

    // R9: unmapped addresses
    readAt(2'd2, 1'b1, v); check("R9 addr2", v, 32'h0);
    readAt(2'd3, 1'b1, v); check("R9 addr3", v, 32'h0);
    @(negedge clk);
    rdEn = 1'b0;
    check("R9 no consume", {31'b0, entReq}, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule